// File: doc/BRIEF.md
# Two-Agent Invalidation Coherence Line Controller

This block keeps a small set of cache lines coherent between this cache and one peer. Each line carries a four-state tag (Invalid, Shared, Exclusive, Modified) and a data word in a register array. The local agent issues one read or write at a time. The block answers it from the array when the tag allows it. Otherwise it first obtains the line or sole ownership over a message bus.

The bus works in both directions. Each direction carries one message per cycle under a valid/ready handshake. A message has a type, a source id, a line index and a data word. The block sends read requests and invalidate requests for its own transactions. It answers the peer's reads with data and the peer's invalidates with acknowledges. While a transaction is open, or a reply is waiting to go out, further local requests are held off with a busy signal. If neither cache holds a line, the peer side of the bus (peer plus memory) supplies a read response with the memory's value. The line then enters Shared.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: no message is pending, `lreq_busy` and `lrsp_valid` are low, `rx_ready` is high, and the first local read of any line issues a read request.
- R2: A local read of an Invalid line sends a read request (type 0) carrying the line index and the block's own id. A read response (type 1) for that line from another id stores the data, leaves the line Shared and returns the data on `lrsp_data` with `lrsp_valid` high.
- R3: A local read of a line in Shared, Exclusive or Modified returns the stored data one cycle after acceptance and sends no bus message.
- R4: A local write to a Shared line sends an invalidate request (type 2) and stays busy. On the matching invalidate acknowledge (type 3) the line becomes Exclusive. In the following cycle the write lands, the line becomes Modified and the written data is returned, two cycles after the acknowledge is taken.
- R5: A local write to an Exclusive or Modified line updates the data, leaves the line Modified, returns the written data one cycle after acceptance and sends no bus message.
- R6: A local write to an Invalid line first sends a read request. After the response fills the line, the block sends an invalidate request and completes the write as in R4.
- R7: A peer read request for a line this cache holds is answered with a read response carrying the stored data, and the line becomes Shared: a later local write needs an invalidate. A peer read request for an Invalid line gets no answer.
- R8: A peer invalidate request makes the line Invalid and is answered with an invalidate acknowledge carrying the block's id and the same line index.
- R9: While a local transaction is open, `lreq_busy` is high and no new local request is accepted.
- R10: An outgoing message keeps its type, line and data unchanged while `tx_valid` is high and `tx_ready` is low. While it waits, no incoming message is taken.
- R11: A response or acknowledge that matches no open transaction, and any incoming message carrying the block's own id, is consumed and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq_valid | input | 1 | Local request present |
| lreq_write | input | 1 | 1 = write, 0 = read |
| lreq_line | input | LW | Local line index |
| lreq_wdata | input | DW | Local write data |
| lreq_busy | output | 1 | Local request cannot be accepted this cycle |
| lrsp_valid | output | 1 | One-cycle completion pulse |
| lrsp_data | output | DW | Read data, or written data for a write |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Bus takes the outgoing message |
| tx_type | output | 2 | 0 read req, 1 read rsp, 2 inval req, 3 inval ack |
| tx_src | output | IDW | Own id |
| tx_line | output | LW | Outgoing line index |
| tx_data | output | DW | Outgoing data |
| rx_valid | input | 1 | Incoming message valid |
| rx_ready | output | 1 | Block takes the incoming message |
| rx_type | input | 2 | Incoming type, same codes |
| rx_src | input | IDW | Sender id |
| rx_line | input | LW | Incoming line index |
| rx_data | input | DW | Incoming data |

## Verification
A wrong tag is never visible directly. It shows up at the next operation on that line: a read hit that should have been a miss and sends nothing, an extra or missing invalidate request on a write, or a peer read that goes unanswered or returns stale data. The bench therefore follows every state change with a probe on the same line. A peer read, a local read or a local write reveals the tag within a few cycles. Data corruption shows in the next response on either side.

// File: rtl/mesi_lc_pkg.sv
package mesi_lc_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } lstate_t;

  typedef enum logic [1:0] {
    M_RDREQ  = 2'd0,
    M_RDRSP  = 2'd1,
    M_INVREQ = 2'd2,
    M_INVACK = 2'd3
  } mtype_t;

  typedef enum logic [1:0] {
    PX_IDLE   = 2'd0,
    PX_FILL   = 2'd1,
    PX_UPG    = 2'd2,
    PX_COMMIT = 2'd3
  } pend_t;

  // line holds valid data that may be read locally
  function automatic logic has_copy(lstate_t s);
    return s != LS_INV;
  endfunction

  // line is held by this cache alone
  function automatic logic owns_line(lstate_t s);
    return (s == LS_EXC) || (s == LS_MOD);
  endfunction

  // tag left behind after a peer read
  function automatic lstate_t after_peer_read(lstate_t s);
    return has_copy(s) ? LS_SHR : LS_INV;
  endfunction

endpackage

// File: rtl/mesi_lc_store.sv
module mesi_lc_store
  import mesi_lc_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DW     = 8,
  parameter int LW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] a_line,
  output lstate_t       a_state,
  output logic [DW-1:0] a_data,
  input  logic [LW-1:0] b_line,
  output lstate_t       b_state,
  output logic [DW-1:0] b_data,
  input  logic          upd_en,
  input  logic [LW-1:0] upd_line,
  input  lstate_t       upd_state,
  input  logic          upd_wen,
  input  logic [DW-1:0] upd_data
);

  lstate_t       st_q  [NLINES];
  logic [DW-1:0] dat_q [NLINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NLINES; i++) begin
      if (!rst_n) begin
        st_q[i]  <= LS_INV;
        dat_q[i] <= '0;
      end else if (upd_en && (upd_line == LW'(i))) begin
        st_q[i] <= upd_state;
        if (upd_wen) dat_q[i] <= upd_data;
      end
    end
  end

  assign a_state = st_q[a_line];
  assign a_data  = dat_q[a_line];
  assign b_state = st_q[b_line];
  assign b_data  = dat_q[b_line];

endmodule

// File: rtl/mesi_lc_txslot.sv
module mesi_lc_txslot
  import mesi_lc_pkg::*;
#(
  parameter int LW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  mtype_t        ld_type,
  input  logic [LW-1:0] ld_line,
  input  logic [DW-1:0] ld_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output mtype_t        tx_type,
  output logic [LW-1:0] tx_line,
  output logic [DW-1:0] tx_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_type  <= M_RDREQ;
      tx_line  <= '0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_type  <= ld_type;
      tx_line  <= ld_line;
      tx_data  <= ld_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_lc_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DW     = 8,
  parameter int IDW    = 2,
  parameter logic [IDW-1:0] MY_ID = 1,
  localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lreq_valid,
  input  logic           lreq_write,
  input  logic [LW-1:0]  lreq_line,
  input  logic [DW-1:0]  lreq_wdata,
  output logic           lreq_busy,
  output logic           lrsp_valid,
  output logic [DW-1:0]  lrsp_data,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [1:0]     tx_type,
  output logic [IDW-1:0] tx_src,
  output logic [LW-1:0]  tx_line,
  output logic [DW-1:0]  tx_data,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [1:0]     rx_type,
  input  logic [IDW-1:0] rx_src,
  input  logic [LW-1:0]  rx_line,
  input  logic [DW-1:0]  rx_data
);

  pend_t         pst_q, pst_n;
  logic [LW-1:0] pline_q;
  logic          pwr_q;
  logic [DW-1:0] pdata_q;

  lstate_t       loc_state, peer_state;
  logic [DW-1:0] loc_data, peer_data;

  logic          upd_en, upd_wen;
  logic [LW-1:0] upd_line;
  lstate_t       upd_state;
  logic [DW-1:0] upd_data;

  logic          tx_load;
  mtype_t        tx_ld_type, tx_type_e;
  logic [LW-1:0] tx_ld_line;
  logic [DW-1:0] tx_ld_data;

  logic          rsp_set;
  logic [DW-1:0] rsp_val;
  logic          pw_load;

  // named internal events for the checker
  logic lreq_acc, rx_fire, rx_foreign, pend_active;
  logic ev_hit_read, ev_hit_write, ev_upg_ack, peer_hit;

  mtype_t rx_kind;
  assign rx_kind = mtype_t'(rx_type);

  mesi_lc_store #(.NLINES(NLINES), .DW(DW), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_line(lreq_line), .a_state(loc_state), .a_data(loc_data),
    .b_line(rx_line), .b_state(peer_state), .b_data(peer_data),
    .upd_en(upd_en), .upd_line(upd_line), .upd_state(upd_state),
    .upd_wen(upd_wen), .upd_data(upd_data)
  );

  mesi_lc_txslot #(.LW(LW), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(tx_load), .ld_type(tx_ld_type), .ld_line(tx_ld_line), .ld_data(tx_ld_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_type(tx_type_e),
    .tx_line(tx_line), .tx_data(tx_data)
  );

  assign tx_type     = tx_type_e;
  assign tx_src      = MY_ID;
  assign pend_active = (pst_q != PX_IDLE);
  assign rx_ready    = !tx_valid && (pst_q != PX_COMMIT);
  assign rx_fire     = rx_valid && rx_ready;
  assign rx_foreign  = rx_src != MY_ID;
  assign lreq_busy   = pend_active || tx_valid || rx_valid;
  assign lreq_acc    = lreq_valid && !lreq_busy;

  always_comb begin
    tx_load      = 1'b0;
    tx_ld_type   = M_RDREQ;
    tx_ld_line   = lreq_line;
    tx_ld_data   = '0;
    upd_en       = 1'b0;
    upd_line     = lreq_line;
    upd_state    = LS_INV;
    upd_wen      = 1'b0;
    upd_data     = lreq_wdata;
    rsp_set      = 1'b0;
    rsp_val      = lreq_wdata;
    pst_n        = pst_q;
    pw_load      = 1'b0;
    ev_hit_read  = 1'b0;
    ev_hit_write = 1'b0;
    ev_upg_ack   = 1'b0;
    peer_hit     = 1'b0;
    if (pst_q == PX_COMMIT) begin
      upd_en    = 1'b1;
      upd_line  = pline_q;
      upd_state = LS_MOD;
      upd_wen   = 1'b1;
      upd_data  = pdata_q;
      rsp_set   = 1'b1;
      rsp_val   = pdata_q;
      pst_n     = PX_IDLE;
    end else if (lreq_acc) begin
      pw_load = 1'b1;
      if (!lreq_write && has_copy(loc_state)) begin
        ev_hit_read = 1'b1;
        rsp_set     = 1'b1;
        rsp_val     = loc_data;
      end else if (lreq_write && owns_line(loc_state)) begin
        ev_hit_write = 1'b1;
        upd_en       = 1'b1;
        upd_state    = LS_MOD;
        upd_wen      = 1'b1;
        rsp_set      = 1'b1;
      end else if (lreq_write && (loc_state == LS_SHR)) begin
        tx_load    = 1'b1;
        tx_ld_type = M_INVREQ;
        pst_n      = PX_UPG;
      end else begin
        tx_load    = 1'b1;
        tx_ld_type = M_RDREQ;
        pst_n      = PX_FILL;
      end
    end else if (rx_fire && rx_foreign) begin
      tx_ld_line = rx_line;
      upd_line   = rx_line;
      unique case (rx_kind)
        M_RDREQ: if (has_copy(peer_state)) begin
          peer_hit   = 1'b1;
          tx_load    = 1'b1;
          tx_ld_type = M_RDRSP;
          tx_ld_data = peer_data;
          upd_en     = 1'b1;
          upd_state  = after_peer_read(peer_state);
        end
        M_INVREQ: begin
          upd_en     = 1'b1;
          upd_state  = LS_INV;
          tx_load    = 1'b1;
          tx_ld_type = M_INVACK;
        end
        M_RDRSP: if ((pst_q == PX_FILL) && (rx_line == pline_q)) begin
          upd_en    = 1'b1;
          upd_state = LS_SHR;
          upd_wen   = 1'b1;
          upd_data  = rx_data;
          if (pwr_q) begin
            tx_load    = 1'b1;
            tx_ld_type = M_INVREQ;
            pst_n      = PX_UPG;
          end else begin
            rsp_set = 1'b1;
            rsp_val = rx_data;
            pst_n   = PX_IDLE;
          end
        end
        M_INVACK: if ((pst_q == PX_UPG) && (rx_line == pline_q)) begin
          ev_upg_ack = 1'b1;
          upd_en     = 1'b1;
          upd_state  = LS_EXC;
          pst_n      = PX_COMMIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst_q      <= PX_IDLE;
      pline_q    <= '0;
      pwr_q      <= 1'b0;
      pdata_q    <= '0;
      lrsp_valid <= 1'b0;
      lrsp_data  <= '0;
    end else begin
      pst_q      <= pst_n;
      lrsp_valid <= rsp_set;
      if (rsp_set) lrsp_data <= rsp_val;
      if (pw_load) begin
        pline_q <= lreq_line;
        pwr_q   <= lreq_write;
        pdata_q <= lreq_wdata;
      end
    end
  end

endmodule

module mesi_line_ctrl_chk #(
  parameter int IDW = 2,
  parameter int LW  = 2,
  parameter int DW  = 8,
  parameter logic [IDW-1:0] MY_ID = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [1:0]     tx_type,
  input logic [LW-1:0]  tx_line,
  input logic [DW-1:0]  tx_data,
  input logic           rx_fire,
  input logic           rx_ready,
  input logic [1:0]     rx_type,
  input logic [IDW-1:0] rx_src,
  input logic           lrsp_valid,
  input logic           lreq_valid,
  input logic           lreq_busy,
  input logic           pend_active,
  input logic           ev_hit_read,
  input logic           ev_hit_write,
  input logic           ev_upg_ack,
  input logic           peer_hit
);

  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_type) && $stable(tx_line) && $stable(tx_data));

  a_r10_no_rx_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  a_r3_hit_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_read |=> lrsp_valid && !tx_valid);

  a_r5_hit_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_write |=> lrsp_valid && !tx_valid);

  a_r4_commit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upg_ack |=> ##1 lrsp_valid);

  a_r7_peer_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    peer_hit |=> tx_valid && (tx_type == 2'd1));

  a_r8_inval_acked: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire && (rx_type == 2'd2) && (rx_src != MY_ID) |=> tx_valid && (tx_type == 2'd3));

  a_r9_busy_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    pend_active && lreq_valid |-> lreq_busy);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDW(IDW), .LW(LW), .DW(DW), .MY_ID(MY_ID)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_type(tx_type), .tx_line(tx_line), .tx_data(tx_data),
  .rx_fire(rx_fire), .rx_ready(rx_ready), .rx_type(rx_type), .rx_src(rx_src),
  .lrsp_valid(lrsp_valid), .lreq_valid(lreq_valid), .lreq_busy(lreq_busy),
  .pend_active(pend_active), .ev_hit_read(ev_hit_read), .ev_hit_write(ev_hit_write),
  .ev_upg_ack(ev_upg_ack), .peer_hit(peer_hit)
);

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;
  localparam int NL = 4, DW = 8, LW = 2, IDW = 2;
  localparam logic [IDW-1:0] ME = 2'd1, PEER = 2'd2;
  localparam logic [1:0] T_RREQ = 2'd0, T_RRSP = 2'd1, T_IREQ = 2'd2, T_IACK = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lreq_valid = 1'b0, lreq_write = 1'b0;
  logic [LW-1:0] lreq_line = '0;
  logic [DW-1:0] lreq_wdata = '0;
  logic lreq_busy, lrsp_valid;
  logic [DW-1:0] lrsp_data;
  logic tx_valid, tx_ready = 1'b1;
  logic [1:0] tx_type;
  logic [IDW-1:0] tx_src;
  logic [LW-1:0] tx_line;
  logic [DW-1:0] tx_data;
  logic rx_valid = 1'b0, rx_ready;
  logic [1:0] rx_type = '0;
  logic [IDW-1:0] rx_src = '0;
  logic [LW-1:0] rx_line = '0;
  logic [DW-1:0] rx_data = '0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.NLINES(NL), .DW(DW), .IDW(IDW), .MY_ID(ME)) uut (
    .clk(clk), .rst_n(rst_n), .lreq_valid(lreq_valid), .lreq_write(lreq_write),
    .lreq_line(lreq_line), .lreq_wdata(lreq_wdata), .lreq_busy(lreq_busy),
    .lrsp_valid(lrsp_valid), .lrsp_data(lrsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_type(tx_type), .tx_src(tx_src), .tx_line(tx_line), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_type(rx_type), .rx_src(rx_src),
    .rx_line(rx_line), .rx_data(rx_data)
  );

  int checks = 0, errors = 0;
  int tx_cnt = 0, rsp_cnt = 0, tx_seen = 0, rsp_seen = 0;
  logic [1:0] c_type;
  logic [IDW-1:0] c_src;
  logic [LW-1:0] c_line;
  logic [DW-1:0] c_data, r_data;
  bit done = 0;

  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      tx_cnt <= tx_cnt + 1;
      c_type <= tx_type; c_src <= tx_src; c_line <= tx_line; c_data <= tx_data;
    end
    if (lrsp_valid) begin
      rsp_cnt <= rsp_cnt + 1;
      r_data  <= lrsp_data;
    end
  end

  function automatic logic [DW-1:0] fill_val(int l, int round);
    return DW'(8'h30 + l * 17 + round * 64);
  endfunction
  function automatic logic [DW-1:0] wr_val(int l, int round);
    return DW'((8'hA5 ^ (l * 9)) + round * 3);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic lreq(input logic wr, input int l, input logic [DW-1:0] d);
    @(negedge clk);
    lreq_valid = 1'b1; lreq_write = wr; lreq_line = LW'(l); lreq_wdata = d;
    while (lreq_busy) @(negedge clk);
    @(negedge clk);
    lreq_valid = 1'b0;
  endtask

  task automatic send(input logic [1:0] ty, input int l, input logic [DW-1:0] d, input logic [IDW-1:0] src);
    @(negedge clk);
    rx_valid = 1'b1; rx_type = ty; rx_line = LW'(l); rx_data = d; rx_src = src;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_tx(input string req, input logic [1:0] ty, input int l,
                         input logic [DW-1:0] d, input bit use_data);
    int n;
    n = 0;
    while (tx_cnt == tx_seen && n < 30) begin @(negedge clk); n++; end
    chk(req, tx_cnt, tx_seen + 1, "message count");
    chk(req, c_type, ty, "message type");
    chk(req, c_src, ME, "message source");
    chk(req, c_line, l, "message line");
    if (use_data) chk(req, c_data, d, "message data");
    tx_seen = tx_cnt;
  endtask

  task automatic wait_rsp(input string req, input logic [DW-1:0] d);
    int n;
    n = 0;
    while (rsp_cnt == rsp_seen && n < 30) begin @(negedge clk); n++; end
    chk(req, rsp_cnt, rsp_seen + 1, "completion count");
    chk(req, r_data, d, "completion data");
    rsp_seen = rsp_cnt;
  endtask

  task automatic quiet(input string req, input int cyc);
    repeat (cyc) @(negedge clk);
    chk(req, tx_cnt, tx_seen, "no bus message");
    chk(req, rsp_cnt, rsp_seen, "no completion");
    tx_seen = tx_cnt; rsp_seen = rsp_cnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] h_line;
    logic [1:0] h_type;
    logic [DW-1:0] h_data;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", tx_valid, 0, "tx_valid after reset");
    chk("R1", lreq_busy, 0, "busy after reset");
    chk("R1", lrsp_valid, 0, "lrsp_valid after reset");
    chk("R1", rx_ready, 1, "rx_ready after reset");

    // R7 peer read of invalid lines is not answered; R1/R2 first read misses
    for (int l = 0; l < NL; l++) begin
      send(T_RREQ, l, 8'h00, PEER);
      quiet("R7", 4);
      lreq(1'b0, l, 8'h00);
      wait_tx("R2", T_RREQ, l, 8'h00, 1'b0);
      send(T_RRSP, l, fill_val(l, 0), PEER);
      wait_rsp("R2", fill_val(l, 0));
      lreq(1'b0, l, 8'h00);
      wait_rsp("R3", fill_val(l, 0));
      quiet("R3", 3);
    end

    // R4 write to shared line, R5 write to owned line
    for (int l = 0; l < NL; l++) begin
      lreq(1'b1, l, wr_val(l, 0));
      wait_tx("R4", T_IREQ, l, 8'h00, 1'b0);
      chk("R9", lreq_busy, 1, "busy while invalidate open");
      send(T_IACK, l, 8'h00, PEER);
      wait_rsp("R4", wr_val(l, 0));
      lreq(1'b1, l, wr_val(l, 1));
      wait_rsp("R5", wr_val(l, 1));
      quiet("R5", 3);
      lreq(1'b0, l, 8'h00);
      wait_rsp("R3", wr_val(l, 1));
    end

    // R11 stray responses and own-id messages
    send(T_IACK, 0, 8'h00, PEER);
    send(T_RRSP, 0, 8'hEE, PEER);
    send(T_IREQ, 1, 8'h00, ME);
    quiet("R11", 3);
    lreq(1'b0, 0, 8'h00);
    wait_rsp("R11", wr_val(0, 1));
    lreq(1'b0, 1, 8'h00);
    wait_rsp("R11", wr_val(1, 1));
    quiet("R11", 2);

    // R7 peer read of modified lines supplies data and downgrades
    for (int l = 0; l < NL; l++) begin
      send(T_RREQ, l, 8'h00, PEER);
      wait_tx("R7", T_RRSP, l, wr_val(l, 1), 1'b1);
      lreq(1'b1, l, wr_val(l, 2));
      wait_tx("R7", T_IREQ, l, 8'h00, 1'b0);
      send(T_IACK, l, 8'h00, PEER);
      wait_rsp("R4", wr_val(l, 2));
    end

    // R8 peer invalidate
    for (int l = 0; l < NL; l++) begin
      send(T_IREQ, l, 8'h00, PEER);
      wait_tx("R8", T_IACK, l, 8'h00, 1'b0);
      lreq(1'b0, l, 8'h00);
      wait_tx("R8", T_RREQ, l, 8'h00, 1'b0);
      send(T_RRSP, l, fill_val(l, 1), PEER);
      wait_rsp("R2", fill_val(l, 1));
    end

    // R6 write to invalid line
    send(T_IREQ, 3, 8'h00, PEER);
    wait_tx("R8", T_IACK, 3, 8'h00, 1'b0);
    lreq(1'b1, 3, wr_val(3, 5));
    wait_tx("R6", T_RREQ, 3, 8'h00, 1'b0);
    send(T_RRSP, 3, fill_val(3, 2), PEER);
    wait_tx("R6", T_IREQ, 3, 8'h00, 1'b0);
    chk("R9", lreq_busy, 1, "busy during write miss");
    send(T_IACK, 3, 8'h00, PEER);
    wait_rsp("R6", wr_val(3, 5));
    send(T_RREQ, 3, 8'h00, PEER);
    wait_tx("R6", T_RRSP, 3, wr_val(3, 5), 1'b1);

    // R10 hold under back-pressure
    @(negedge clk);
    tx_ready = 1'b0;
    send(T_RREQ, 0, 8'h00, PEER);
    h_type = tx_type; h_line = tx_line; h_data = tx_data;
    chk("R10", tx_valid, 1, "message pending");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", {tx_valid, tx_type, tx_line, tx_data}, {1'b1, h_type, h_line, h_data}, "held message");
      chk("R10", rx_ready, 0, "rx blocked while waiting");
    end
    tx_ready = 1'b1;
    wait_tx("R10", T_RRSP, 0, fill_val(0, 1), 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule